// File: doc/BRIEF.md
# Shift-OR Bitmap Multi-Pattern Matcher

This block scans one byte stream for several fixed patterns at the same time. It stores no mask table. Each incoming byte passes through one symbol encoder, which gives it a small code. One bitmap decoder then turns that code into one-hot symbol lines. All patterns share these two stages. Each pattern builds its mismatch mask by inverting the lines chosen by its own characters. It keeps a private shift-OR state vector and drives one bit of a registered match vector.

The patterns and the alphabet are elaboration-time parameters. `LANES` selects how many bytes are consumed per clock, either 1 or 2. With two lanes, every pattern state is advanced twice in one cycle, older byte first. A hit at either step raises that pattern's flag. The block suits a payload inspector that has to report which signatures ended at each position of the stream.

Top module: `sor_multi_matcher`

## Requirements
- R1: Reset clears every match flag and empties every pattern state, so no prefix seen before reset can complete a pattern afterwards.
- R2: Bytes 0x61 to 0x67 are the alphabet and get codes 0 to 6. Every other byte gets the reserved code 7, which activates no symbol line. Such a byte therefore matches no pattern position and breaks every partial match.
- R3: With one lane, flag bit p is set after the valid byte that completes pattern p. The default patterns are: bit 0 "aadc", bit 1 "bdd", bit 2 "ddac", bit 3 "aabcd", bit 4 "dd".
- R4: Overlapping and repeated occurrences are each reported, including occurrences that complete on consecutive bytes.
- R5: Flags of different patterns are independent and can be set in the same cycle.
- R6: While in_valid is low, the bytes are ignored and every pattern state is held. All flags are 0 in the following cycle, and matching resumes across the gap as if the valid bytes were contiguous.
- R7: With two lanes, in_bytes[7:0] is the older byte and in_bytes[15:8] the newer one. A pattern's flag is set if the pattern completes at either byte, including patterns that span a cycle boundary.
- R8: Flags are registered and change only on the clock edge that takes in the completing byte. A flag lasts one cycle unless the next valid byte completes the same pattern again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | All lanes of in_bytes carry stream bytes this cycle |
| in_bytes | input | LANES*8 | Stream bytes; lane 0 (bits 7:0) is the oldest |
| match_o | output | NUM_PAT | Per-pattern match flag, bit p for pattern p |

## Verification
Two things can fall in the same cycle: completions of different patterns, and, with two lanes, two completions of the same pattern. The stream "bdd" ends "bdd" and "dd" on one byte. In the two-lane instance, a cycle carrying "dd" after a previous "d" completes "dd" at both lanes. The bench judges every cycle against a reference that compares the stream history against each pattern string and ORs the positions that fall within one cycle.

// File: rtl/sor_pkg.sv
package sor_pkg;

   // Default alphabet: a contiguous run of byte values.
   localparam int DEF_ALPHA_BASE = 97;
   localparam int DEF_ALPHA_N    = 7;

   // Default pattern set; each entry right-aligned, first character highest.
   localparam int DEF_NUM_PAT = 5;
   localparam int DEF_MAX_LEN = 5;
   localparam logic [DEF_MAX_LEN*8-1:0] DEF_PATTERNS [DEF_NUM_PAT] = '{
      40'("aadc"), 40'("bdd"), 40'("ddac"), 40'("aabcd"), 40'("dd")};
   localparam int DEF_PAT_LEN [DEF_NUM_PAT] = '{4, 3, 4, 5, 2};

   // Symbol code of a byte; n (one past the last symbol) marks a non-member.
   function automatic int sym_code(logic [7:0] b, int base, int n);
      int v;
      v = int'(b);
      if (v >= base && v < base + n) return v - base;
      return n;
   endfunction

endpackage

// File: rtl/sor_sym_encoder.sv
module sor_sym_encoder #(
   parameter int ALPHA_BASE = sor_pkg::DEF_ALPHA_BASE,
   parameter int ALPHA_N    = sor_pkg::DEF_ALPHA_N,
   parameter int CODE_W     = $clog2(ALPHA_N + 1)
) (
   input  logic [7:0]        in_byte,
   output logic [CODE_W-1:0] code_o
);

   if (ALPHA_N >= (1 << CODE_W)) begin : g_bad_code_w
      $error("code width leaves no room for the reserved code");
   end

   always_comb begin
      code_o = CODE_W'(sor_pkg::sym_code(in_byte, ALPHA_BASE, ALPHA_N));
   end

endmodule

// File: rtl/sor_bitmap_decoder.sv
module sor_bitmap_decoder #(
   parameter int ALPHA_N = sor_pkg::DEF_ALPHA_N,
   parameter int CODE_W  = $clog2(ALPHA_N + 1)
) (
   input  logic [CODE_W-1:0]  code_i,
   output logic [ALPHA_N-1:0] lines_o
);

   for (genvar k = 0; k < ALPHA_N; k++) begin : g_line
      assign lines_o[k] = (code_i == CODE_W'(k));
   end

endmodule

// File: rtl/sor_pattern_engine.sv
module sor_pattern_engine #(
   parameter int LANES      = 1,
   parameter int ALPHA_BASE = sor_pkg::DEF_ALPHA_BASE,
   parameter int ALPHA_N    = sor_pkg::DEF_ALPHA_N,
   parameter int MAX_LEN    = sor_pkg::DEF_MAX_LEN,
   parameter int LEN        = 2,
   parameter logic [MAX_LEN*8-1:0] PAT = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [LANES-1:0][ALPHA_N-1:0]   lines,
   output logic                            match_o
);

   localparam logic [LEN-1:0] EMPTY_STATE = '1;

   if (LEN < 1 || LEN > MAX_LEN) begin : g_bad_len
      $error("pattern length out of range");
   end

   // Mismatch mask per lane: bit i is 0 only when the byte equals character i.
   logic [LANES-1:0][LEN-1:0] smask;

   for (genvar i = 0; i < LEN; i++) begin : g_char
      localparam int CI = sor_pkg::sym_code(PAT[8*(LEN-1-i) +: 8], ALPHA_BASE, ALPHA_N);
      if (CI >= ALPHA_N) begin : g_bad_char
         $error("pattern character outside the alphabet");
      end else begin : g_wire
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign smask[l][i] = ~lines[l][CI];
         end
      end
   end

   // Bit k of the state is 0 when the last k+1 bytes equal the first k+1 characters.
   logic [LEN-1:0] state_q;
   logic [LEN-1:0] state_nxt;
   logic           hit;
   logic           match_q;

   always_comb begin
      logic [LEN-1:0] stage;
      stage = state_q;
      hit   = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         stage = (stage << 1) | smask[l];
         if (!stage[LEN-1]) hit = 1'b1;
      end
      state_nxt = stage;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= EMPTY_STATE;
         match_q <= 1'b0;
      end else begin
         match_q <= in_valid & hit;
         if (in_valid) state_q <= state_nxt;
      end
   end

   assign match_o = match_q;

   assert_idle_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !match_q);

   assert_idle_holds_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(state_q));

   assert_reset_empty_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (state_q == EMPTY_STATE));

   assert_flag_after_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      match_q |-> $past(in_valid));

endmodule

// File: rtl/sor_multi_matcher.sv
module sor_multi_matcher #(
   parameter int LANES      = 1,
   parameter int ALPHA_BASE = sor_pkg::DEF_ALPHA_BASE,
   parameter int ALPHA_N    = sor_pkg::DEF_ALPHA_N,
   parameter int NUM_PAT    = sor_pkg::DEF_NUM_PAT,
   parameter int MAX_LEN    = sor_pkg::DEF_MAX_LEN,
   parameter logic [MAX_LEN*8-1:0] PATTERNS [NUM_PAT] = sor_pkg::DEF_PATTERNS,
   parameter int PAT_LEN [NUM_PAT] = sor_pkg::DEF_PAT_LEN
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [LANES*8-1:0] in_bytes,
   output logic [NUM_PAT-1:0] match_o
);

   localparam int CODE_W   = $clog2(ALPHA_N + 1);
   localparam int RESERVED = ALPHA_N;

   if (LANES != 1 && LANES != 2) begin : g_bad_lanes
      $error("LANES must be 1 or 2");
   end
   if (ALPHA_N < 1 || ALPHA_BASE < 0 || ALPHA_BASE + ALPHA_N > 256) begin : g_bad_alpha
      $error("alphabet does not fit in a byte");
   end
   if (NUM_PAT < 1) begin : g_bad_num
      $error("at least one pattern is needed");
   end

   logic [LANES-1:0][CODE_W-1:0]  lane_code;
   logic [LANES-1:0][ALPHA_N-1:0] lane_lines;

   // Shared front end: one encoder and one decoder per lane, used by all patterns.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      sor_sym_encoder #(
         .ALPHA_BASE(ALPHA_BASE),
         .ALPHA_N   (ALPHA_N),
         .CODE_W    (CODE_W)
      ) u_enc (
         .in_byte(in_bytes[l*8 +: 8]),
         .code_o (lane_code[l])
      );

      sor_bitmap_decoder #(
         .ALPHA_N(ALPHA_N),
         .CODE_W (CODE_W)
      ) u_dec (
         .code_i (lane_code[l]),
         .lines_o(lane_lines[l])
      );

      assert_reserved_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_code[l] == CODE_W'(RESERVED)) |-> (lane_lines[l] == '0));

      assert_lines_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(lane_lines[l]));
   end

   for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
      sor_pattern_engine #(
         .LANES     (LANES),
         .ALPHA_BASE(ALPHA_BASE),
         .ALPHA_N   (ALPHA_N),
         .MAX_LEN   (MAX_LEN),
         .LEN       (PAT_LEN[p]),
         .PAT       (PATTERNS[p])
      ) u_eng (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_valid(in_valid),
         .lines   (lane_lines),
         .match_o (match_o[p])
      );
   end

endmodule

// File: tb/tb_sor_multi_matcher.sv
`timescale 1ns/1ps
module tb_sor_multi_matcher;

   localparam int NP = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          v1;
   logic [7:0]    b1;
   logic [NP-1:0] m1;
   logic          v2;
   logic [15:0]   b2;
   logic [NP-1:0] m2;

   sor_multi_matcher #(.LANES(1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_bytes(b1), .match_o(m1));

   sor_multi_matcher #(.LANES(2)) dut_q2 (
      .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_bytes(b2), .match_o(m2));

   string pats [NP] = '{"aadc", "bdd", "ddac", "aabcd", "dd"};
   byte   h1 [$];
   byte   h2 [$];
   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;

   function automatic bit ends_with(byte h [$], int e, string s);
      if (e + 1 < s.len()) return 1'b0;
      for (int i = 0; i < s.len(); i++)
         if (h[e - s.len() + 1 + i] != s[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check(logic [NP-1:0] act, logic [NP-1:0] exp, string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step1(bit v, byte c, string req);
      logic [NP-1:0] exp;
      v1 = v; b1 = c; exp = '0;
      if (v) begin
         h1.push_back(c);
         for (int p = 0; p < NP; p++) exp[p] = ends_with(h1, h1.size() - 1, pats[p]);
      end
      @(negedge clk);
      check(m1, exp, req);
   endtask

   task automatic feed1(string s, string req);
      for (int i = 0; i < s.len(); i++) step1(1'b1, s[i], req);
   endtask

   task automatic step2(bit v, byte c0, byte c1, string req);
      logic [NP-1:0] exp;
      v2 = v; b2 = {c1, c0}; exp = '0;
      if (v) begin
         h2.push_back(c0);
         h2.push_back(c1);
         for (int p = 0; p < NP; p++)
            exp[p] = ends_with(h2, h2.size() - 2, pats[p]) | ends_with(h2, h2.size() - 1, pats[p]);
      end
      @(negedge clk);
      check(m2, exp, req);
   endtask

   task automatic feed2(string s, string req);
      for (int i = 0; i + 1 < s.len(); i += 2) step2(1'b1, s[i], s[i+1], req);
   endtask

   task automatic t_reset_R1;
      check(m1, '0, "R1 reset flags q1");
      check(m2, '0, "R1 reset flags q2");
      rst_n = 1'b1;
      step1(1'b1, "d", "R1 no carried prefix q1");
      step1(1'b1, "c", "R1 no carried prefix q1");
      step2(1'b1, "d", "c", "R1 no carried prefix q2");
   endtask

   task automatic t_basic_R3;
      feed1("zaadc", "R3 aadc");
      feed1("zbdd", "R3 bdd");
      feed1("zddac", "R3 ddac");
      feed1("zaabcd", "R3 aabcd");
   endtask

   task automatic t_alphabet_R2;
      feed1("zaa", "R2 prefix");
      step1(1'b1, 8'h68, "R2 byte past alphabet");
      feed1("dc", "R2 broken by 0x68");
      step1(1'b1, 8'h60, "R2 byte before alphabet");
      feed1("dd", "R2 after 0x60");
      feed1("bdgd", "R2 g breaks bdd");
      feed1("aadc", "R2 resume after break");
   endtask

   task automatic t_overlap_R4;
      feed1("zaaadc", "R4 aaadc");
      feed1("zddddac", "R4 ddddac");
   endtask

   task automatic t_concurrent_R5;
      feed1("zbdd", "R5 bdd with dd");
      feed1("ddac", "R5 dd then ddac");
   endtask

   task automatic t_gap_R6;
      feed1("zaa", "R6 prefix");
      step1(1'b0, "x", "R6 idle byte ignored");
      step1(1'b0, "d", "R6 idle byte ignored");
      feed1("dc", "R6 resume across gap");
      feed1("zbd", "R6 prefix");
      step1(1'b0, "d", "R6 idle completing byte gives no flag");
      step1(1'b1, "z", "R6 state held through idle");
   endtask

   task automatic t_latency_R8;
      logic [NP-1:0] exp;
      feed1("zaad", "R8 prefix");
      v1 = 1'b1; b1 = "c"; h1.push_back("c");
      #1;
      check(m1, '0, "R8 no flag before edge");
      exp = '0;
      exp[0] = 1'b1;
      @(negedge clk);
      check(m1, exp, "R8 flag after edge");
      step1(1'b1, "z", "R8 one-cycle pulse");
   endtask

   task automatic t_two_lanes_R7;
      feed2("123aabcd", "R7 payload");
      feed2("aabcdz", "R7 end in lane 0");
      feed2("zbddzz", "R7 bdd and dd");
      feed2("zdddzz", "R7 dd in both lanes");
      feed2("zaad", "R7 prefix");
      step2(1'b0, "c", "c", "R7 idle q2");
      feed2("cz", "R7 resume q2");
      feed2("zddacz", "R7 spans cycles");
   endtask

   initial begin
      v1 = 1'b0; b1 = '0; v2 = 1'b0; b2 = '0;
      repeat (3) @(negedge clk);
      t_reset_R1();
      t_basic_R3();
      t_alphabet_R2();
      t_overlap_R4();
      t_concurrent_R5();
      t_gap_R6();
      t_latency_R8();
      t_two_lanes_R7();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule